// File: doc/BRIEF.md
# Buffered Program Sequencer for a Parallel NOR Flash

This block accepts the multi-cycle write-to-buffer programming handshake of a parallel NOR flash and applies the result to a small behavioural flash array. A host first writes the buffer-request command (E8h in the low data byte). It then reads the extended status byte to learn whether the buffer was granted. A busy device ignores the request, so the host simply repeats it until the grant bit shows 1 or its own timeout runs out.

Once granted, the host writes a word count, coded as N-1, with an address inside the target block. It then writes N data words with their addresses, the first of which becomes the start address. A final confirm cycle either starts programming or abandons the whole sequence. Programming commits one buffered word every `PROG_CYC` clock cycles. Flash semantics apply: a program can only clear bits. The array can be read at any time through a combinational read port, and a status byte reports ready and the two error flags.

Top module: `bufprog_seq`

## Requirements
- R1: After reset `busy` is 0, `xstat` is 80h, `stat` is 80h and every array word reads FFFFh.
- R2: `xstat` bit 7 is 1 whenever no programming is in progress and 0 while it is; bits 6..0 always read 0. A write whose low byte is E8h, issued while not busy and with no sequence open, opens a sequence.
- R3: While `busy` is 1, every write is ignored: no request, clear or data write changes the status flags or the sequence outcome.
- R4: The count cycle carries N-1 in `wr_data`. A value above BUF_WORDS-1 (default 15) aborts the sequence and sets `stat` bit 4 (program error).
- R5: Data cycles whose address leaves the block given in the count cycle (block = address bits AW-1..BLK_AW), lies below the start address, or lies more than N-1 above it abort the sequence, set `stat` bit 4 and program nothing.
- R6: A confirm cycle with low byte D0h after the last data word starts programming. `busy` rises on the next cycle. Buffered word k (in arrival order) is committed exactly (k+1)*PROG_CYC cycles after the confirm edge, and `busy` falls on the edge that commits the last word.
- R7: Any other confirm value aborts the sequence, sets `stat` bit 5 (command-sequence error), discards the buffer and leaves the array unchanged.
- R8: With no sequence open and not busy, a write with low byte 50h clears `stat` bits 5 and 4. Any other low byte except E8h is ignored.
- R9: A committed word becomes the bitwise AND of the old array word and the buffered data, so bits only go from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW (7) | Word address of the write |
| wr_data | input | DW (16) | Command, count, data or confirm value |
| rd_addr | input | AW (7) | Array read address |
| rd_data | output | DW (16) | Array word at `rd_addr` (combinational) |
| xstat | output | 8 | Extended status; bit 7 = buffer available |
| stat | output | 8 | Status; bit 7 ready, bit 5 command-sequence error, bit 4 program error |
| busy | output | 1 | Programming in progress |

## Verification
The bench targets the window edges in R5. An address exactly N-1 above the start is legal, one further is not. An address one below the start is also illegal. A design with an off-by-one window would either reject a full buffer or program a stray word. A count of exactly 16 has to trip the program error, and a design that compares against the buffer size instead of its last index would accept it and overrun storage. A request or clear written during programming must be dropped. Otherwise a design would start a new sequence underneath the running one or lose an error flag. The per-cycle reference model catches any commit that lands one cycle early or late, and any OR-style program that sets bits back to 1.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_DATA  = 3'd2,
    ST_CONF  = 3'd3,
    ST_PROG  = 3'd4
  } seq_state_e;

  localparam logic [7:0] CMD_BUF_REQ = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLR_ERR = 8'h50;
endpackage

// File: rtl/bufprog_buf.sv
module bufprog_buf #(
  parameter int AW        = 7,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 16,
  localparam int BIW      = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BIW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [BIW-1:0] ridx,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_q [BUF_WORDS];
  logic [DW-1:0] data_q [BUF_WORDS];

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_slot
    logic hit;
    assign hit = we && (widx == BIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (hit) begin
        addr_q[g] <= waddr;
        data_q[g] <= wdata;
      end
    end
  end

  assign raddr = addr_q[ridx];
  assign rdata = data_q[ridx];
endmodule

// File: rtl/bufprog_array.sv
module bufprog_array #(
  parameter int AW    = 7,
  parameter int DW    = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= mem_q[waddr] & wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R9: a program never sets a bit that was clear
  p_and_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == '0));
endmodule

// File: rtl/bufprog_fsm.sv
module bufprog_fsm
  import bufprog_pkg::*;
#(
  parameter int AW        = 7,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 16,
  parameter int BLK_WORDS = 32,
  parameter int PROG_CYC  = 4,
  localparam int BIW      = $clog2(BUF_WORDS),
  localparam int BLKW     = $clog2(BLK_WORDS),
  localparam int TW       = $clog2(PROG_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           buf_we,
  output logic [BIW-1:0] buf_widx,
  output logic [BIW-1:0] buf_ridx,
  output logic           arr_we,
  output logic           busy,
  output logic           prog_err,
  output logic           cseq_err
);
  seq_state_e        state_q, state_d;
  logic [BIW-1:0]    cnt_q, cnt_d;
  logic [BIW-1:0]    idx_q, idx_d;
  logic [BIW-1:0]    pidx_q, pidx_d;
  logic [AW-1:0]     start_q, start_d;
  logic [AW-BLKW-1:0] blk_q, blk_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              perr_q, perr_d;
  logic              cerr_q, cerr_d;

  logic [7:0]        cmd;
  logic [AW-1:0]     start_eff;
  logic [AW-1:0]     offs;
  logic              in_blk, in_win, addr_ok, cnt_ok, tick;

  assign cmd       = wr_data[7:0];
  assign start_eff = (idx_q == '0) ? wr_addr : start_q;
  assign offs      = wr_addr - start_eff;
  assign in_blk    = (wr_addr[AW-1:BLKW] == blk_q);
  assign in_win    = (wr_addr >= start_eff) && (offs <= AW'(cnt_q));
  assign addr_ok   = in_blk && in_win;
  assign cnt_ok    = (wr_data <= DW'(BUF_WORDS - 1));
  assign tick      = (tmr_q == TW'(PROG_CYC - 1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    pidx_d   = pidx_q;
    start_d  = start_q;
    blk_d    = blk_q;
    tmr_d    = tmr_q;
    perr_d   = perr_q;
    cerr_d   = cerr_q;
    buf_we   = 1'b0;
    arr_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_en) begin
          if (cmd == CMD_BUF_REQ) begin
            state_d = ST_COUNT;
          end else if (cmd == CMD_CLR_ERR) begin
            perr_d = 1'b0;
            cerr_d = 1'b0;
          end
        end
      end
      ST_COUNT: begin
        if (wr_en) begin
          if (!cnt_ok) begin
            perr_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_d   = wr_data[BIW-1:0];
            blk_d   = wr_addr[AW-1:BLKW];
            idx_d   = '0;
            state_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (wr_en) begin
          if (!addr_ok) begin
            perr_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            buf_we  = 1'b1;
            start_d = start_eff;
            idx_d   = idx_q + 1'b1;
            if (idx_q == cnt_q) state_d = ST_CONF;
          end
        end
      end
      ST_CONF: begin
        if (wr_en) begin
          if (cmd == CMD_CONFIRM) begin
            state_d = ST_PROG;
            tmr_d   = '0;
            pidx_d  = '0;
          end else begin
            cerr_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (tick) begin
          arr_we = 1'b1;
          tmr_d  = '0;
          pidx_d = pidx_q + 1'b1;
          if (pidx_q == cnt_q) state_d = ST_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      pidx_q  <= '0;
      start_q <= '0;
      blk_q   <= '0;
      tmr_q   <= '0;
      perr_q  <= 1'b0;
      cerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      pidx_q  <= pidx_d;
      start_q <= start_d;
      blk_q   <= blk_d;
      tmr_q   <= tmr_d;
      perr_q  <= perr_d;
      cerr_q  <= cerr_d;
    end
  end

  assign buf_widx = idx_q;
  assign buf_ridx = pidx_q;
  assign busy     = (state_q == ST_PROG);
  assign prog_err = perr_q;
  assign cseq_err = cerr_q;

  // R4: an accepted count never exceeds the last buffer index
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && wr_en && wr_data > DW'(BUF_WORDS - 1)) |=> (state_q == ST_IDLE && perr_q));
  // R5: data index stays inside the announced count
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q <= cnt_q));
  // R6: a D0h confirm enters programming on the next cycle
  p_prog_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONF && wr_en && cmd == CMD_CONFIRM) |=> busy);
  // R7: any other confirm value flags a sequence error and closes the sequence
  p_bad_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONF && wr_en && cmd != CMD_CONFIRM) |=> (cerr_q && state_q == ST_IDLE));
  // R3: error flags cannot move while programming
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(perr_q) && $stable(cerr_q)));
  // R6: the commit pointer never passes the last buffered word
  p_pidx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pidx_q <= cnt_q));
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq #(
  parameter int AW        = 7,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 16,
  parameter int BLK_WORDS = 32,
  parameter int PROG_CYC  = 4,
  localparam int BIW      = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    xstat,
  output logic [7:0]    stat,
  output logic          busy
);
  logic           buf_we, arr_we, perr, cerr;
  logic [BIW-1:0] buf_widx, buf_ridx;
  logic [AW-1:0]  pend_addr;
  logic [DW-1:0]  pend_data;

  bufprog_fsm #(
    .AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS),
    .BLK_WORDS(BLK_WORDS), .PROG_CYC(PROG_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
    .arr_we(arr_we), .busy(busy), .prog_err(perr), .cseq_err(cerr)
  );

  bufprog_buf #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .widx(buf_widx), .waddr(wr_addr), .wdata(wr_data),
    .ridx(buf_ridx), .raddr(pend_addr), .rdata(pend_data)
  );

  bufprog_array #(.AW(AW), .DW(DW)) arr_i (
    .clk(clk), .rst_n(rst_n),
    .we(arr_we), .waddr(pend_addr), .wdata(pend_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign xstat = {~busy, 7'b0};
  assign stat  = {~busy, 1'b0, cerr, perr, 4'b0};

  // R2: buffer-available bit is low exactly while the array is being written
  p_xsr_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (xstat[7] == 1'b0));
endmodule

// File: tb/bufprog_seq_tb_top.sv
`timescale 1ns/1ps
module bufprog_seq_tb_top;
  localparam int AW = 7, DW = 16, BUFW = 16, BLKW = 32, PC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    xstat, stat;
  logic          busy;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  bufprog_seq #(.AW(AW), .DW(DW), .BUF_WORDS(BUFW), .BLK_WORDS(BLKW), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xstat(xstat), .stat(stat), .busy(busy)
  );

  // behavioural reference: 0 idle, 1 count, 2 data, 3 confirm, 4 programming
  int      m_st, m_cnt, m_start, m_blk, m_tmr, m_pidx;
  bit      m_perr, m_cerr;
  int      q_a[$];
  int      q_d[$];
  logic [DW-1:0] m_arr [1 << AW];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_perr = 0; m_cerr = 0; m_tmr = 0; m_pidx = 0;
      for (int i = 0; i < (1 << AW); i++) m_arr[i] = '1;
    end else begin
      case (m_st)
        0: if (wr_en) begin
             if (wr_data[7:0] == 8'hE8) m_st = 1;
             else if (wr_data[7:0] == 8'h50) begin m_perr = 0; m_cerr = 0; end
           end
        1: if (wr_en) begin
             if (int'(wr_data) > BUFW - 1) begin m_perr = 1; m_st = 0; end
             else begin
               m_cnt = int'(wr_data); m_blk = int'(wr_addr) / BLKW;
               q_a.delete(); q_d.delete(); m_st = 2;
             end
           end
        2: if (wr_en) begin
             int a;
             a = int'(wr_addr);
             if (q_a.size() == 0) m_start = a;
             if (a / BLKW != m_blk || a < m_start || a - m_start > m_cnt) begin
               m_perr = 1; m_st = 0;
             end else begin
               q_a.push_back(a); q_d.push_back(int'(wr_data));
               if (q_a.size() == m_cnt + 1) m_st = 3;
             end
           end
        3: if (wr_en) begin
             if (wr_data[7:0] == 8'hD0) begin m_st = 4; m_tmr = 0; m_pidx = 0; end
             else begin m_cerr = 1; m_st = 0; end
           end
        4: begin
             m_tmr++;
             if (m_tmr == PC) begin
               m_arr[q_a[m_pidx]] = m_arr[q_a[m_pidx]] & DW'(q_d[m_pidx]);
               m_tmr = 0; m_pidx++;
               if (m_pidx == m_cnt + 1) m_st = 0;
             end
           end
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison against the reference, 1 ns after each edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit mb;
      #1;
      mb = (m_st == 4);
      n_run++;
      if (busy !== mb) begin n_fail++; $display("FAIL R6 busy act=%0b exp=%0b t=%0t", busy, mb, $time); end
      n_run++;
      if (xstat !== (mb ? 8'h00 : 8'h80)) begin
        n_fail++; $display("FAIL R2 xstat act=%h exp=%h t=%0t", xstat, (mb ? 8'h00 : 8'h80), $time);
      end
      n_run++;
      if (stat !== {~mb, 1'b0, m_cerr, m_perr, 4'b0}) begin
        n_fail++; $display("FAIL R4 stat act=%h exp=%h t=%0t", stat, {~mb, 1'b0, m_cerr, m_perr, 4'b0}, $time);
      end
      n_run++;
      if (rd_data !== m_arr[rd_addr]) begin
        n_fail++; $display("FAIL R6 rd_data act=%h exp=%h t=%0t", rd_data, m_arr[rd_addr], $time);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic peek(input int a, input logic [15:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0;
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 xstat", 16'(xstat), 16'h80);
    chk("R1 stat", 16'(stat), 16'h80);
    chk("R1 array", rd_data, 16'hFFFF);
    rst_n = 1'b1;
    idle(2);

    // R2/R6: four-word program into block 1
    wr(0, 'hE8); idle(1);
    chk("R2 granted", 16'(xstat), 16'h80);
    wr(32, 3);
    wr(40, 'h1234); wr(41, 'hABCD); wr(42, 'h0F0F); wr(43, 'h5555);
    wr(32, 'hD0); idle(1);
    chk("R6 busy after confirm", 16'(busy), 16'h1);
    chk("R2 unavailable while busy", 16'(xstat), 16'h00);
    wr(0, 'hE8); idle(1);          // R3: request while busy is dropped
    idle(4 * PC);
    chk("R6 done", 16'(busy), 16'h0);
    wr(0, 3); idle(1);             // R8: would be a count if the request had stuck
    chk("R3 no sequence opened", 16'(stat), 16'h80);
    peek(40, 16'h1234, "R6 word0");
    peek(41, 16'hABCD, "R6 word1");
    peek(42, 16'h0F0F, "R6 word2");
    peek(43, 16'h5555, "R6 word3");

    // R9: reprogramming clears bits only
    wr(0, 'hE8); wr(32, 0); wr(40, 'h00FF); wr(32, 'hD0); idle(PC + 3);
    peek(40, 16'h0034, "R9 and-only");

    // R4: count 16 is one past the last index
    wr(0, 'hE8); wr(0, 16); idle(1);
    chk("R4 program error", 16'(stat), 16'h90);
    wr(5, 'h0000); idle(1);
    peek(5, 16'hFFFF, "R4 no data taken");

    // R3: clear during programming is dropped
    wr(0, 'hE8); wr(0, 1); wr(0, 'hAAAA); wr(1, 'h5555); wr(0, 'hD0);
    wr(0, 'h50); idle(2 * PC + 3);
    chk("R3 error kept", 16'(stat), 16'h90);
    peek(0, 16'hAAAA, "R3 prog ok");
    peek(1, 16'h5555, "R3 prog ok");

    // R8: clear in idle
    wr(0, 'h50); idle(1);
    chk("R8 cleared", 16'(stat), 16'h80);

    // R5: block, below-start and beyond-window aborts
    wr(0, 'hE8); wr(64, 1); wr(64, 'h1111); wr(96, 'h2222); idle(1);
    chk("R5 out of block", 16'(stat), 16'h90);
    wr(0, 'h50);
    wr(0, 'hE8); wr(64, 1); wr(66, 'h1111); wr(65, 'h2222); idle(1);
    chk("R5 below start", 16'(stat), 16'h90);
    wr(0, 'h50);
    wr(0, 'hE8); wr(64, 1); wr(64, 'h1111); wr(66, 'h2222); idle(1);
    chk("R5 beyond window", 16'(stat), 16'h90);
    wr(0, 'h50); idle(PC * 3);
    peek(64, 16'hFFFF, "R5 nothing programmed");
    peek(66, 16'hFFFF, "R5 nothing programmed");
    // R5: last legal offset N-1 accepted
    wr(0, 'hE8); wr(64, 2); wr(70, 'h0001); wr(72, 'h0002); wr(71, 'h0003); wr(64, 'hD0);
    idle(3 * PC + 3);
    peek(72, 16'h0002, "R5 window edge");

    // R7: bad confirm
    wr(0, 'hE8); wr(64, 0); wr(80, 'h0000); wr(64, 'h00FF); idle(PC + 3);
    chk("R7 sequence error", 16'(stat), 16'hA0);
    peek(80, 16'hFFFF, "R7 discarded");

    // R8: unknown command ignored
    wr(0, 'h50); wr(0, 'h0003); wr(81, 'h0000); idle(PC + 3);
    chk("R8 ignored", 16'(stat), 16'h80);
    peek(81, 16'hFFFF, "R8 ignored");

    // R6: full 16-word buffer
    wr(0, 'hE8); wr(96, 15);
    for (int i = 0; i < 16; i++) wr(96 + i, i);
    wr(96, 'hD0); idle(16 * PC + 3);
    peek(111, 16'h000F, "R6 full buffer");
    peek(96, 16'h0000, "R6 full buffer");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule